// File: doc/BRIEF.md
# Memory Map Chip-Select Decoder

This block turns a 16-bit bus address into active-high chip selects for three devices: a 2 KB EEPROM, a 2 KB RAM and a 4-byte peripheral I/O window. It also gives the address offset within the selected device and a flag for addresses that no device claims. A mode input picks the decode style on every cycle. In exact mode every address bit is compared, so each device appears once in the 64 KB space. In alias mode only the top one or two address bits are examined, so the devices repeat across the map and every address belongs to some device.

All outputs come from one register stage, so they follow the address and mode by one clock cycle. That stage can be removed with a parameter, which leaves the decode purely combinational. A synchronous active-high reset clears every output.

Top module: `memmap_cs_decoder`

## Requirements
- R1: In exact mode (`alias_mode`=0), `cs_eeprom` is high only for addresses 0x0000..0x07FF, and `dev_offset` then equals address bits 10:0.
- R2: In exact mode, `cs_ram` is high only for addresses 0x8000..0x87FF, and `dev_offset` then equals address bits 10:0.
- R3: In exact mode, `cs_pio` is high only for addresses 0xFFFC..0xFFFF. `dev_offset` then holds address bits 1:0 in bits 1:0, and its bits 10:2 are zero.
- R4: In exact mode, any other address leaves all three selects low, drives `unmapped` high and drives `dev_offset` to zero.
- R5: In alias mode (`alias_mode`=1), `cs_eeprom` is high exactly when address bit 15 is 0, so the EEPROM repeats every 2 KB from 0x0000 to 0x7800. `dev_offset` is address bits 10:0.
- R6: In alias mode, `cs_ram` is high exactly when address bits 15:14 are 2'b10, so the RAM repeats every 2 KB from 0x8000 to 0xB800. `dev_offset` is address bits 10:0.
- R7: In alias mode, `cs_pio` is high exactly when address bits 15:14 are 2'b11, so the peripheral repeats every 4 bytes from 0xC000. `dev_offset` is address bits 1:0, zero-extended.
- R8: In alias mode, `unmapped` is always low.
- R9: For any address in either mode, at most one of the three chip selects is high.
- R10: With the default registered build, the outputs for the address and mode that were present at a rising clock edge appear right after that edge. A change of mode takes effect in the same cycle as a change of address.
- R11: While `rst` is high at a rising edge, all selects, `unmapped` and `dev_offset` are driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Address to decode |
| alias_mode | input | 1 | 0 = exact decode, 1 = aliased decode using only the top bits |
| cs_eeprom | output | 1 | EEPROM select |
| cs_ram | output | 1 | RAM select |
| cs_pio | output | 1 | Peripheral I/O select |
| dev_offset | output | 11 | Offset within the selected device, zero when none is selected |
| unmapped | output | 1 | High in exact mode when no device claims the address |

## Verification
The mode switch and the address decode can both change in the same cycle. If the mode were registered apart from the address, the block would briefly give a result that mixes the old mode with the new address. The bench provokes this by changing the mode and the address together on consecutive cycles, at addresses where the two modes disagree (for example 0x1000, 0x9000 and 0xC001). It judges each cycle against a model of both modes. The full 65536-address sweep in each mode covers every boundary of the three windows.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int AW     = 16;
  localparam int OFF_W  = 11;
  localparam int NUM_DEV = 3;

  typedef enum int {DEV_EEPROM = 0, DEV_RAM = 1, DEV_PIO = 2} dev_e;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [4:0]    span_w;
    logic [AW-1:0] alias_mask;
    logic [AW-1:0] alias_val;
  } region_t;

  function automatic region_t region_cfg(input int idx);
    region_t r;
    case (idx)
      DEV_EEPROM: r = '{base: 16'h0000, span_w: 5'd11, alias_mask: 16'h8000, alias_val: 16'h0000};
      DEV_RAM:    r = '{base: 16'h8000, span_w: 5'd11, alias_mask: 16'hC000, alias_val: 16'h8000};
      default:    r = '{base: 16'hFFFC, span_w: 5'd2,  alias_mask: 16'hC000, alias_val: 16'hC000};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mm_region_match.sv
module mm_region_match #(
  parameter int AW = 16,
  parameter int OFF_W = 11,
  parameter logic [AW-1:0] BASE = '0,
  parameter int SPAN_W = 11,
  parameter logic [AW-1:0] ALIAS_MASK = '0,
  parameter logic [AW-1:0] ALIAS_VAL = '0
) (
  input  logic [AW-1:0]    addr,
  input  logic             alias_mode,
  output logic             hit,
  output logic [OFF_W-1:0] offset
);
  localparam logic [AW-1:0] LOW_MASK = {AW{1'b1}} >> (AW - SPAN_W);

  logic exact_hit, alias_hit;

  always_comb begin
    exact_hit = (addr & ~LOW_MASK) == (BASE & ~LOW_MASK);
    alias_hit = (addr & ALIAS_MASK) == ALIAS_VAL;
    hit       = alias_mode ? alias_hit : exact_hit;
    offset    = hit ? (addr[OFF_W-1:0] & LOW_MASK[OFF_W-1:0]) : '0;
  end
endmodule

// File: rtl/mm_out_stage.sv
module mm_out_stage #(
  parameter int W = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REGISTERED) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
      end
      assign q = q_r;
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/memmap_cs_decoder.sv
module memmap_cs_decoder
  import memmap_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             alias_mode,
  output logic             cs_eeprom,
  output logic             cs_ram,
  output logic             cs_pio,
  output logic [OFF_W-1:0] dev_offset,
  output logic             unmapped
);
  localparam int OUT_W = NUM_DEV + OFF_W + 1;

  logic [NUM_DEV-1:0] hit;
  logic [OFF_W-1:0]   off_each [NUM_DEV];
  logic [OFF_W-1:0]   off_merged;
  logic               unmapped_c;
  logic [OUT_W-1:0]   stage_d, stage_q;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_region
    localparam region_t CFG = region_cfg(i);
    mm_region_match #(
      .AW(AW), .OFF_W(OFF_W),
      .BASE(CFG.base), .SPAN_W(int'(CFG.span_w)),
      .ALIAS_MASK(CFG.alias_mask), .ALIAS_VAL(CFG.alias_val)
    ) match_i (
      .addr(bus_addr), .alias_mode(alias_mode),
      .hit(hit[i]), .offset(off_each[i])
    );
  end

  always_comb begin
    off_merged = '0;
    for (int i = 0; i < NUM_DEV; i++) off_merged = off_merged | off_each[i];
    unmapped_c = !alias_mode && (hit == '0);
    stage_d = {hit, off_merged, unmapped_c};
  end

  mm_out_stage #(.W(OUT_W), .REGISTERED(REGISTERED)) out_i (
    .clk(clk), .rst(rst), .d(stage_d), .q(stage_q)
  );

  assign cs_eeprom  = stage_q[OUT_W-1-(NUM_DEV-1-DEV_EEPROM)];
  assign cs_ram     = stage_q[OUT_W-1-(NUM_DEV-1-DEV_RAM)];
  assign cs_pio     = stage_q[OUT_W-1-(NUM_DEV-1-DEV_PIO)];
  assign dev_offset = stage_q[OFF_W:1];
  assign unmapped   = stage_q[0];
endmodule

// File: rtl/memmap_cs_checker.sv
module memmap_cs_checker #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        alias_mode,
  input logic        cs_eeprom,
  input logic        cs_ram,
  input logic        cs_pio,
  input logic [10:0] dev_offset,
  input logic        unmapped
);
  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_eeprom, cs_ram, cs_pio}));

  // R4
  unmapped_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> !(cs_eeprom || cs_ram || cs_pio) && dev_offset == '0);

  // R3
  pio_offset_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    cs_pio |-> dev_offset[10:2] == '0);

  generate
    if (REGISTERED) begin : g_lat
      // R8
      alias_never_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(alias_mode) |-> !unmapped);

      // R1
      exact_eeprom_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(alias_mode) && $past(bus_addr[15:11]) == 5'd0
        |-> cs_eeprom && dev_offset == $past(bus_addr[10:0]));

      // R5
      alias_eeprom_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(alias_mode) |-> cs_eeprom == !$past(bus_addr[15]));

      // R11
      reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> !cs_eeprom && !cs_ram && !cs_pio && !unmapped && dev_offset == '0);
    end
  endgenerate
endmodule

bind memmap_cs_decoder memmap_cs_checker #(.REGISTERED(REGISTERED)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .alias_mode(alias_mode),
  .cs_eeprom(cs_eeprom), .cs_ram(cs_ram), .cs_pio(cs_pio),
  .dev_offset(dev_offset), .unmapped(unmapped)
);

// File: tb/memmap_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module memmap_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        alias_mode = 1'b0;
  logic        cs_eeprom, cs_ram, cs_pio, unmapped;
  logic [10:0] dev_offset;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memmap_cs_decoder dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .alias_mode(alias_mode),
    .cs_eeprom(cs_eeprom), .cs_ram(cs_ram), .cs_pio(cs_pio),
    .dev_offset(dev_offset), .unmapped(unmapped)
  );

  // expected {eeprom, ram, pio, offset, unmapped} from the requirements
  function automatic logic [14:0] model(input logic [15:0] a, input logic m);
    logic e, r, p, u;
    logic [10:0] o;
    if (!m) begin
      e = (a <= 16'h07FF);                       // R1
      r = (a >= 16'h8000 && a <= 16'h87FF);      // R2
      p = (a >= 16'hFFFC);                       // R3
      u = !(e || r || p);                        // R4
    end else begin
      e = (a[15] == 1'b0);                       // R5
      r = (a[15:14] == 2'b10);                   // R6
      p = (a[15:14] == 2'b11);                   // R7
      u = 1'b0;                                  // R8
    end
    o = p ? {9'd0, a[1:0]} : ((e || r) ? a[10:0] : 11'd0);
    return {e, r, p, o, u};
  endfunction

  function automatic string req_of(input logic [15:0] a, input logic m);
    if (!m) begin
      if (a <= 16'h07FF) return "R1";
      if (a >= 16'h8000 && a <= 16'h87FF) return "R2";
      if (a >= 16'hFFFC) return "R3";
      return "R4";
    end
    if (!a[15]) return "R5";
    if (!a[14]) return "R6";
    return "R7";
  endfunction

  task automatic check_out(input logic [14:0] exp, input string req);
    logic [14:0] act;
    act = {cs_eeprom, cs_ram, cs_pio, dev_offset, unmapped};
    tests++;
    if (act !== exp || $countones({cs_eeprom, cs_ram, cs_pio}) > 1) begin
      fails++;
      $display("FAIL %s (R9/R10) addr=%h mode=%0b actual=%h expected=%h",
               req, bus_addr, alias_mode, act, exp);
    end
  endtask

  // drive on falling edge, sample one cycle later just after the rising edge (R10)
  task automatic apply(input logic [15:0] a, input logic m);
    @(negedge clk);
    bus_addr = a;
    alias_mode = m;
    @(posedge clk);
    #1;
    check_out(model(a, m), req_of(a, m));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    bus_addr = 16'h0010;
    alias_mode = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check_out('0, "R11");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sweep(input logic m);
    for (int a = 0; a < 65536; a++) apply(16'(a), m);
  endtask

  task automatic t_mode_toggle();
    logic [15:0] pts [6] = '{16'h1000, 16'h9000, 16'hC001, 16'h07FF, 16'hFFFD, 16'h8800};
    for (int k = 0; k < 6; k++) begin
      apply(pts[k], 1'b0);
      apply(pts[k], 1'b1);
      apply(pts[(k + 1) % 6], 1'b0);  // R10: mode and address change together
    end
  endtask

  task automatic t_reset_midrun();
    apply(16'h8004, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    bus_addr = 16'h8005;
    @(posedge clk);
    #1;
    check_out('0, "R11");
    @(negedge clk);
    rst = 1'b0;
    apply(16'hFFFE, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_mode_toggle();
    t_reset_midrun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule